// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Per-Word Valid Bits

This block is a direct-mapped, write-through cache placed between a processor's load/store port and the memory system. Each line holds several one-word slots, and each slot has its own valid bit. A load hits only when the line's tag matches and the addressed slot is valid. Any other load fetches the whole line over a single-beat refill port, installs it, and marks every slot valid. The load then completes on the following cycle as a hit.

A store never fetches anything. In the cycle its write-through transfer is accepted by memory, the store writes its word and the line's tag into the cache. If the tag already matched, the other slots keep their valid bits. If the tag did not match, the line is claimed for the new tag and only the written slot stays valid. This is safe because memory always receives every store and so keeps a current copy of any data that is discarded. The processor is stalled by a store only while the memory write port is not ready.

Addresses are word addresses. The lowest bits select the word in the line, the next bits select the line, and the remaining upper bits form the tag.

Top module: `wtc_cache`

## Requirements
- R1: After reset every slot is invalid, `cpu_ready`, `wr_valid` and `rf_req` are low while idle, and the first load to any address misses.
- R2: A load whose tag matches and whose slot is valid raises `cpu_ready` in the same cycle, with the stored word on `cpu_rdata`, and starts no refill.
- R3: A load with a tag mismatch or an invalid slot keeps `cpu_ready` low. From the next cycle it holds `rf_req` high with `rf_addr` equal to `cpu_addr` without its word-select bits, until `rf_valid` is seen.
- R4: A refill installs the tag and all slots. Word w of the line is `rf_data[32*w +: 32]`. In the cycle after `rf_valid` the held load is a hit that returns the refilled word.
- R5: A store raises `wr_valid` in its first cycle with `wr_addr` = `cpu_addr` and `wr_data` = `cpu_wdata`, and holds them stable while `wr_ready` is low.
- R6: A store whose tag matches a valid slot replaces that word, and the slot stays valid, so the next load of it hits with the new value.
- R7: A store whose tag matches but whose slot is invalid writes the word and makes that slot valid. The other slots of the line keep their valid state.
- R8: A store whose tag mismatches sets the line tag to the store's tag and makes only the written slot valid. Loads of the other slots, and of the old tag, miss.
- R9: `cpu_ready` for a store is high exactly in the cycle `wr_ready` is high. The cache updates in that same cycle, so a load of the word on the next cycle hits.
- R10: A store never raises `rf_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW (16) | Word address |
| cpu_wdata | input | DW (32) | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW (32) | Load data, valid with `cpu_ready` |
| wr_valid | output | 1 | Write-through transfer offered |
| wr_ready | input | 1 | Memory accepts the write-through transfer |
| wr_addr | output | AW (16) | Write-through word address |
| wr_data | output | DW (32) | Write-through data |
| rf_req | output | 1 | Line refill request |
| rf_addr | output | AW-2 (14) | Line address to refill |
| rf_valid | input | 1 | Refill line data present |
| rf_data | input | WORDS*DW (128) | Refill line, word w at bits 32*w |

## Verification
Two actions share one cycle: memory accepting the write-through transfer and the cache updating its slot, tag and valid bits. This is provoked by holding `wr_ready` low for zero, one or two cycles on stores that hit, that hit an invalid slot, and that take over a line from another tag. Each store is judged by an immediate load of the same word, which must hit with the new data. Loads of the sibling slots must then hit or miss as a bench-side model of tags and valid bits predicts. A shadow memory, updated only on accepted write-through transfers, supplies refill data and checks every returned word.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through cache.
// Assumes: nothing beyond standard SystemVerilog.
package wtc_pkg;
    typedef enum logic {
        ST_LOOKUP = 1'b0,   // serving hits and stores
        ST_FILL   = 1'b1    // waiting for a line refill
    } wtc_state_t;
endpackage

// File: rtl/wtc_tagstore.sv
// Tag array and per-word valid bits for a direct-mapped cache.
// Computes hit for the looked-up word and applies the store/fill valid rules.
// Assumes fill_en and st_en are never high together.
module wtc_tagstore #(
    parameter int LINES = 128,
    parameter int WORDS = 4,
    parameter int TAG_W = 7,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [OFS_W-1:0] lk_word,
    input  logic             st_en,
    input  logic             fill_en,
    output logic             hit
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic             tag_eq;
    logic [WORDS-1:0] word_oh;

    // Compare the stored tag and decode the addressed word.
    always_comb begin
        tag_eq  = (tag_q[lk_idx] == lk_tag);
        word_oh = WORDS'(1) << lk_word;
        hit     = tag_eq && vld_q[lk_idx][lk_word];
    end

    // Valid bits: clear on reset, all set on fill, store rules otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
        end else if (fill_en) begin
            vld_q[lk_idx] <= '1;
        end else if (st_en) begin
            vld_q[lk_idx] <= tag_eq ? (vld_q[lk_idx] | word_oh) : word_oh;
        end
    end

    // Tag written by every fill and every accepted store.
    always_ff @(posedge clk) begin
        if (fill_en || st_en) tag_q[lk_idx] <= lk_tag;
    end
endmodule

// File: rtl/wtc_datastore.sv
// Data array split into one bank per word of the line.
// A store writes one bank; a fill writes all banks of the line.
// Assumes fill_en and st_en are never high together.
module wtc_datastore #(
    parameter int LINES = 128,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic [IDX_W-1:0]    idx,
    input  logic [OFS_W-1:0]    word,
    input  logic                st_en,
    input  logic [DW-1:0]       st_data,
    input  logic                fill_en,
    input  logic [WORDS*DW-1:0] fill_line,
    output logic [DW-1:0]       rd_word
);
    logic [DW-1:0] bank_out [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [DW-1:0] bank_q [LINES];

        // One word bank: loaded by fills, or by stores to this word.
        always_ff @(posedge clk) begin
            if (fill_en) begin
                bank_q[idx] <= fill_line[w*DW +: DW];
            end else if (st_en && (word == OFS_W'(w))) begin
                bank_q[idx] <= st_data;
            end
        end

        assign bank_out[w] = bank_q[idx];
    end

    // Select the addressed word.
    assign rd_word = bank_out[word];
endmodule

// File: rtl/wtc_ctrl.sv
// Request sequencer: completes hits and stores, runs the refill wait.
// Assumes the processor holds cpu_req, cpu_we and the address until cpu_ready.
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic hit,
    input  logic wr_ready,
    input  logic rf_valid,
    output logic cpu_ready,
    output logic wr_valid,
    output logic rf_req,
    output logic st_en,
    output logic fill_en
);
    wtc_state_t state_q, state_d;

    // Decode outputs and next state from the current request.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        wr_valid  = 1'b0;
        rf_req    = 1'b0;
        st_en     = 1'b0;
        fill_en   = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && cpu_we) begin
                    wr_valid  = 1'b1;
                    cpu_ready = wr_ready;
                    st_en     = wr_ready;
                end else if (cpu_req) begin
                    cpu_ready = hit;
                    if (!hit) state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                rf_req = 1'b1;
                if (rf_valid) begin
                    fill_en = 1'b1;
                    state_d = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wtc_cache.sv
// Top of the direct-mapped write-through cache with per-word valid bits.
// Splits the word address, joins the tag store, data store and sequencer.
// Assumes word addresses and a processor that holds requests until cpu_ready.
module wtc_cache #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    parameter int LINES = 128,
    localparam int OFS_W = $clog2(WORDS),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = AW - OFS_W - IDX_W,
    localparam int LA_W  = AW - OFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [AW-1:0]       cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    output logic                cpu_ready,
    output logic [DW-1:0]       cpu_rdata,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [AW-1:0]       wr_addr,
    output logic [DW-1:0]       wr_data,
    output logic                rf_req,
    output logic [LA_W-1:0]     rf_addr,
    input  logic                rf_valid,
    input  logic [WORDS*DW-1:0] rf_data
);
    logic [OFS_W-1:0] a_word;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic             hit, st_en, fill_en;

    // Address fields.
    assign a_word = cpu_addr[OFS_W-1:0];
    assign a_idx  = cpu_addr[OFS_W +: IDX_W];
    assign a_tag  = cpu_addr[AW-1 -: TAG_W];

    // Outgoing transfers carry the held request.
    assign wr_addr = cpu_addr;
    assign wr_data = cpu_wdata;
    assign rf_addr = cpu_addr[AW-1:OFS_W];

    wtc_tagstore #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(a_idx), .lk_tag(a_tag),
        .lk_word(a_word), .st_en(st_en), .fill_en(fill_en), .hit(hit)
    );

    wtc_datastore #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
        .clk(clk), .idx(a_idx), .word(a_word), .st_en(st_en),
        .st_data(cpu_wdata), .fill_en(fill_en), .fill_line(rf_data),
        .rd_word(cpu_rdata)
    );

    wtc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .hit(hit), .wr_ready(wr_ready), .rf_valid(rf_valid),
        .cpu_ready(cpu_ready), .wr_valid(wr_valid), .rf_req(rf_req),
        .st_en(st_en), .fill_en(fill_en)
    );
endmodule

// File: rtl/wtc_chk.sv
// Protocol checker for wtc_cache, attached by bind.
// Assumes the processor holds its request stable until cpu_ready.
module wtc_chk #(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int LA_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_req,
    input logic            cpu_we,
    input logic [AW-1:0]   cpu_addr,
    input logic            cpu_ready,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic            rf_req,
    input logic [LA_W-1:0] rf_addr,
    input logic            rf_valid
);
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5
    AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |-> (wr_valid && wr_ready)); // R9
    AST_NO_FILL_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !rf_req); // R10
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_valid) |=> (rf_req && $stable(rf_addr))); // R3
    AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> !cpu_ready); // R3
    AST_FILL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> (rf_addr == cpu_addr[AW-1:AW-LA_W])); // R3
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_valid) ##1 (cpu_req && !cpu_we && $stable(cpu_addr)) |-> cpu_ready); // R4
endmodule

bind wtc_cache wtc_chk #(.AW(AW), .DW(DW), .LA_W(LA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rf_req(rf_req), .rf_addr(rf_addr), .rf_valid(rf_valid)
);

// File: tb/sim_wtc_cache.sv
`timescale 1ns/1ps
// Bench: directed store cases plus a sweep over 4 tags x 4 lines x 4 words,
// with a shadow memory and a tag/valid model built from the requirements.
module sim_wtc_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         wr_valid, wr_ready = 1'b0;
    logic [15:0]  wr_addr;
    logic [31:0]  wr_data;
    logic         rf_req, rf_valid = 1'b0;
    logic [13:0]  rf_addr;
    logic [127:0] rf_data = '0;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] shadow [64];
    logic [1:0]  mdl_tag [4];
    logic [3:0]  mdl_vld [4];
    int fill_dly = 0;

    always #10 clk = ~clk;

    wtc_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rf_req(rf_req),
        .rf_addr(rf_addr), .rf_valid(rf_valid), .rf_data(rf_data)
    );

    task automatic chk(input bit ok, input string lbl, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", lbl, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] full_addr(input logic [5:0] a);
        return {5'd0, a[5:4], 5'd0, a[3:2], a[1:0]};
    endfunction

    task automatic do_read(input logic [5:0] a, input string lbl);
        logic [1:0] t = a[5:4], i = a[3:2], w = a[1:0];
        bit exp_hit = (mdl_tag[i] == t) && mdl_vld[i][w];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = full_addr(a);
        #1;
        chk(cpu_ready == exp_hit, lbl, 32'(cpu_ready), 32'(exp_hit));
        if (exp_hit) begin
            chk(cpu_rdata == shadow[a], "R2 data", cpu_rdata, shadow[a]);
        end else begin
            @(negedge clk);
            chk(rf_req == 1'b1, "R3 req", 32'(rf_req), 1);
            chk(rf_addr == {5'd0, t, 5'd0, i}, "R3 addr", 32'(rf_addr), 32'({5'd0, t, 5'd0, i}));
            chk(cpu_ready == 1'b0, "R3 stall", 32'(cpu_ready), 0);
            for (int d = 0; d < fill_dly; d++) begin
                @(negedge clk);
                chk(rf_req && !cpu_ready, "R3 wait", 32'({rf_req, cpu_ready}), 32'b10);
            end
            fill_dly = (fill_dly + 1) % 3;
            for (int k = 0; k < 4; k++) rf_data[32*k +: 32] = shadow[{t, i, 2'(k)}];
            rf_valid = 1'b1;
            @(posedge clk);
            #1 rf_valid = 1'b0;
            mdl_tag[i] = t; mdl_vld[i] = 4'hF;
            chk(cpu_ready == 1'b1, "R4 hit", 32'(cpu_ready), 1);
            chk(cpu_rdata == shadow[a], "R4 data", cpu_rdata, shadow[a]);
            chk(rf_req == 1'b0, "R4 done", 32'(rf_req), 0);
        end
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input int stall, input string lbl);
        logic [1:0] t = a[5:4], i = a[3:2], w = a[1:0];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = full_addr(a); cpu_wdata = d;
        wr_ready = (stall == 0);
        #1;
        chk(wr_valid && wr_addr == full_addr(a), {lbl, " R5 addr"}, 32'(wr_addr), 32'(full_addr(a)));
        chk(wr_data == d, "R5 data", wr_data, d);
        chk(rf_req == 1'b0, "R10", 32'(rf_req), 0);
        for (int s = 0; s < stall; s++) begin
            chk(cpu_ready == 1'b0, "R9 stall", 32'(cpu_ready), 0);
            @(negedge clk);
            chk(wr_valid && wr_addr == full_addr(a) && wr_data == d, "R5 hold", 32'(wr_valid), 1);
            chk(rf_req == 1'b0, "R10", 32'(rf_req), 0);
        end
        wr_ready = 1'b1;
        #1;
        chk(cpu_ready == 1'b1, "R9 done", 32'(cpu_ready), 1);
        @(posedge clk);
        #1 cpu_req = 1'b0; wr_ready = 1'b0;
        shadow[a] = d;
        if (mdl_tag[i] == t) mdl_vld[i][w] = 1'b1;
        else begin mdl_tag[i] = t; mdl_vld[i] = 4'b0001 << w; end
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int k = 0; k < 64; k++) shadow[k] = 32'hC0DE0000 + 32'(k) * 32'h01010101;
        for (int k = 0; k < 4; k++) begin mdl_tag[k] = '0; mdl_vld[k] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !wr_valid && !rf_req, "R1 idle", 32'({cpu_ready, wr_valid, rf_req}), 0);
        do_read(6'b00_01_00, "R1 first miss");
        do_read(6'b00_01_01, "R2 hit");
        do_write(6'b00_01_01, 32'h1111_0001, 0, "R6");
        do_read(6'b00_01_01, "R6 reread");
        do_write(6'b01_10_00, 32'h2222_0000, 1, "R8");
        do_write(6'b01_10_11, 32'h2222_0003, 0, "R7");
        do_read(6'b01_10_11, "R7 new word");
        do_read(6'b01_10_00, "R7 kept word");
        do_read(6'b01_10_01, "R7 other invalid");
        do_read(6'b00_11_00, "R8 prefill");
        do_write(6'b10_11_10, 32'h3333_0002, 2, "R8");
        do_read(6'b10_11_10, "R9 next-cycle hit");
        do_read(6'b10_11_01, "R8 sibling miss");
        do_read(6'b00_11_00, "R8 old tag miss");
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[7]) do_write(lf[5:0], {lf, ~lf} ^ 32'(n), int'(lf[9:8]) % 3, "R6 sweep");
            else       do_read(lf[5:0], "R2 sweep");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule